// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block works out which serial flash sits on the bus and reports the geometry that software and the access engines need. It reports the page size in bytes, the shift that places a page number inside a flash address, the number of pages and a revision class. A run starts by itself once reset is released, and again on every `start` pulse while the block is idle. The block does not shift bits. It hands single bytes to an external SPI serializer through a go/done exchange and drives the chip select itself.

Each run opens with an identification frame: the read-ID opcode followed by five dummy bytes, keeping the three leading response bytes. If the first byte is the expected manufacturer code, the device and extension bytes are looked up. Parts that can run either page mode get a second frame, a status read, and status bit 0 picks binary or extended pages. A part that has only the extended mode is reported without that second frame. If the manufacturer byte differs, the block falls back to a status read and decodes a density code from status bits 5..2.

Every run ends with a one-cycle `geo_valid` strobe. A fault code rides on that strobe. The result outputs hold their values until the next strobe.

Top module: `sfg_ident`

## Requirements
- R1: After reset is released the block runs one identification without any `start`. While idle, `cs_n` is 1 and `busy` is 0. During reset `geo_valid`, `page_bytes`, `page_shift`, `page_count` and `rev_d` are 0.
- R2: A run opens a frame with `cs_n` low. Its first exchange sends 0x9F and the next five send 0x00. The replies to exchanges 2, 3 and 4 are the manufacturer, device and extension bytes.
- R3: Between two frames of one run `cs_n` is high for at least one cycle. Every frame starts in the cycle after the internal launch.
- R4: With manufacturer 0x1F and a dual-mode part, a second frame sends 0xD7 and one dummy byte. Status bit 0 = 1 gives binary pages: 256<<k bytes, shift 8+k, `rev_d` = 1.
- R5: On the same path, status bit 0 = 0 gives extended pages: 264<<k bytes, shift 9+k, `rev_d` = 1.
- R6: ID 0x1F2700 makes no status frame. It reports 8192 pages of 528 bytes, shift 10, `rev_d` = 0.
- R7: Dual-mode IDs and their results: 0x1F2200 gives 512 pages (k=0). 0x1F2300 gives 1024 (k=0). 0x1F2400 gives 2048 (k=0). 0x1F2500 gives 4096 (k=0). 0x1F2600 gives 4096 (k=1). 0x1F2701 gives 8192 (k=1). 0x1F2800 gives 8192 (k=2).
- R8: With any other manufacturer byte, a status frame is made and status bits 5..2 are decoded. 0x3 gives 512 pages and 0x5 gives 1024, both with k=0. 0x7 gives 2048 and 0x9 gives 4096, both with k=0. 0xB gives 4096 with k=1. 0xD gives 8192 with k=1. 0xE and 0xF give 8192 with k=2. These are always extended pages with `rev_d` = 0.
- R9: On the fallback path, a status of 0x00 or 0xFF gives `geo_fault` = 1 (no device), with zero geometry and `rev_d` = 0.
- R10: A matching manufacturer with an unlisted ID, or an unlisted density code, gives `geo_fault` = 2 with zero geometry. An unlisted ID makes no status frame. A good result has `geo_fault` = 0.
- R11: `geo_valid` lasts exactly one cycle, with `busy` already 0. `busy` is 1 from the launch until that cycle. A `start` pulse while busy is ignored.
- R12: `xfer_go` is a one-cycle pulse, raised only while `cs_n` is low. It is raised again only after the `xfer_done` for the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new identification while idle |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_go | output | 1 | Ask the serializer to exchange one byte |
| xfer_tx | output | 8 | Byte to send with `xfer_go` |
| xfer_done | input | 1 | Serializer finished the pending exchange |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| busy | output | 1 | Identification in progress |
| geo_valid | output | 1 | One-cycle result strobe |
| geo_fault | output | 2 | 0 good, 1 no device, 2 unsupported |
| page_bytes | output | 11 | Page size in bytes |
| page_shift | output | 4 | Page-number shift inside a flash address |
| page_count | output | 14 | Number of pages |
| rev_d | output | 1 | 1 for parts with both page modes, else 0 |

## Verification
A capture slot that is off by one shows up as a wrong `page_count` or a fault on the very next strobe, because the wrong byte is taken as the device code. A path flag that is stale shows up in two ways. The bench counts the opcodes and frames of every run, so it sees a status frame that should not be there or is missing. The bench also sees extended geometry reported where binary was due. A sequencing fault inside a frame, such as a second request with one already outstanding or chip select rising too early, is flagged in the very cycle it happens. The bench compares the exchange pins on every clock, and the bound properties check them too.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  localparam int PB_W = 11;
  localparam int SH_W = 4;
  localparam int PC_W = 14;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_UNSUP  = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID_RUN,
    PH_ID_CHK,
    PH_ST_RUN,
    PH_ST_CHK
  } phase_e;

  typedef struct packed {
    logic            known;
    logic [1:0]      cls;
    logic [PC_W-1:0] pages;
  } part_t;

  function automatic part_t id_lookup(input logic [7:0] dev, input logic [7:0] ext);
    part_t p;
    p = '0;
    if (ext == 8'h00) begin
      case (dev)
        8'h22, 8'h23, 8'h24, 8'h25: begin
          p.known = 1'b1;
          p.cls   = 2'd0;
          p.pages = PC_W'(512) << (dev[2:0] - 3'd2);
        end
        8'h26: begin p.known = 1'b1; p.cls = 2'd1; p.pages = PC_W'(4096); end
        8'h27: begin p.known = 1'b1; p.cls = 2'd1; p.pages = PC_W'(8192); end
        8'h28: begin p.known = 1'b1; p.cls = 2'd2; p.pages = PC_W'(8192); end
        default: p = '0;
      endcase
    end else if (ext == 8'h01 && dev == 8'h27) begin
      p.known = 1'b1; p.cls = 2'd1; p.pages = PC_W'(8192);
    end
    return p;
  endfunction

  function automatic logic id_dual(input logic [7:0] dev, input logic [7:0] ext);
    return !(dev == 8'h27 && ext == 8'h00);
  endfunction

  function automatic part_t density_lookup(input logic [3:0] code);
    part_t p;
    p = '0;
    p.known = 1'b1;
    case (code)
      4'h3: begin p.cls = 2'd0; p.pages = PC_W'(512);  end
      4'h5: begin p.cls = 2'd0; p.pages = PC_W'(1024); end
      4'h7: begin p.cls = 2'd0; p.pages = PC_W'(2048); end
      4'h9: begin p.cls = 2'd0; p.pages = PC_W'(4096); end
      4'hB: begin p.cls = 2'd1; p.pages = PC_W'(4096); end
      4'hD: begin p.cls = 2'd1; p.pages = PC_W'(8192); end
      4'hE, 4'hF: begin p.cls = 2'd2; p.pages = PC_W'(8192); end
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic logic [PB_W-1:0] geo_bytes(input logic [1:0] cls, input logic pow2);
    return (pow2 ? PB_W'(256) : PB_W'(264)) << cls;
  endfunction

  function automatic logic [SH_W-1:0] geo_shift(input logic [1:0] cls, input logic pow2);
    return SH_W'(8) + SH_W'(cls) + SH_W'(!pow2);
  endfunction

endpackage

// File: rtl/sfg_frame.sv
module sfg_frame #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [7:0]       op,
  input  logic [CNT_W-1:0] n_data,
  output logic             cs_n,
  output logic             xfer_go,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx,
  output logic             rx_stb,
  output logic [CNT_W-1:0] rx_idx,
  output logic [7:0]       rx_byte,
  output logic             frame_end
);

  logic             active, pend;
  logic [CNT_W-1:0] cnt, last;
  logic [7:0]       op_q;
  logic             took;

  assign cs_n      = !active;
  assign xfer_go   = active && !pend;
  assign xfer_tx   = (cnt == '0) ? op_q : 8'h00;
  assign took      = active && pend && xfer_done;
  assign rx_stb    = took && (cnt != '0);
  assign rx_idx    = cnt - CNT_W'(1);
  assign rx_byte   = xfer_rx;
  assign frame_end = took && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
      last   <= '0;
      op_q   <= 8'h00;
    end else if (launch) begin
      active <= 1'b1;
      pend   <= 1'b0;
      cnt    <= '0;
      last   <= n_data;
      op_q   <= op;
    end else begin
      if (xfer_go) pend <= 1'b1;
      if (took) begin
        pend <= 1'b0;
        cnt  <= cnt + CNT_W'(1);
        if (cnt == last) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sfg_match.sv
module sfg_match
  import sfg_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h1F
) (
  input  logic [7:0]      mfr,
  input  logic [7:0]      dev,
  input  logic [7:0]      ext,
  input  logic [7:0]      stat,
  output logic            mfr_hit,
  output logic            id_known,
  output logic            id_dual_mode,
  output logic [1:0]      id_cls,
  output logic [PC_W-1:0] id_pages,
  output logic            stat_absent,
  output logic            leg_known,
  output logic [1:0]      leg_cls,
  output logic [PC_W-1:0] leg_pages
);

  part_t id_p, leg_p;

  assign id_p         = id_lookup(dev, ext);
  assign leg_p        = density_lookup(stat[5:2]);
  assign mfr_hit      = (mfr == MFR_CODE);
  assign id_known     = id_p.known;
  assign id_dual_mode = id_dual(dev, ext);
  assign id_cls       = id_p.cls;
  assign id_pages     = id_p.pages;
  assign stat_absent  = (stat == 8'h00) || (stat == 8'hFF);
  assign leg_known    = leg_p.known;
  assign leg_cls      = leg_p.cls;
  assign leg_pages    = leg_p.pages;

endmodule

// File: rtl/sfg_ident.sv
module sfg_ident
  import sfg_pkg::*;
#(
  parameter logic [7:0] OP_READ_ID   = 8'h9F,
  parameter logic [7:0] OP_READ_STAT = 8'hD7,
  parameter logic [7:0] MFR_CODE     = 8'h1F,
  parameter int         ID_BYTES     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            cs_n,
  output logic            xfer_go,
  output logic [7:0]      xfer_tx,
  input  logic            xfer_done,
  input  logic [7:0]      xfer_rx,
  output logic            busy,
  output logic            geo_valid,
  output logic [1:0]      geo_fault,
  output logic [PB_W-1:0] page_bytes,
  output logic [SH_W-1:0] page_shift,
  output logic [PC_W-1:0] page_count,
  output logic            rev_d
);

  localparam int CNT_W     = $clog2(ID_BYTES + 1);
  localparam int KEY_BYTES = 3;

  phase_e           phase;
  logic             boot_pend, jedec_q, run_req;
  logic [7:0]       id_q [KEY_BYTES];
  logic [7:0]       stat_q;

  // events brought out for the checker
  logic             launch, frame_end, rx_stb, need_stat;
  logic [7:0]       launch_op, rx_byte;
  logic [CNT_W-1:0] launch_n, rx_idx;

  logic             mfr_hit, id_known, id_dual_mode, stat_absent, leg_known;
  logic [1:0]       id_cls, leg_cls;
  logic [PC_W-1:0]  id_pages, leg_pages;

  logic             fin, fin_pow2, fin_rev;
  fault_e           fin_fault;
  logic [1:0]       fin_cls;
  logic [PC_W-1:0]  fin_pages;

  sfg_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(launch_op), .n_data(launch_n),
    .cs_n(cs_n), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .rx_stb(rx_stb), .rx_idx(rx_idx), .rx_byte(rx_byte), .frame_end(frame_end)
  );

  sfg_match #(.MFR_CODE(MFR_CODE)) u_match (
    .mfr(id_q[0]), .dev(id_q[1]), .ext(id_q[2]), .stat(stat_q),
    .mfr_hit(mfr_hit), .id_known(id_known), .id_dual_mode(id_dual_mode),
    .id_cls(id_cls), .id_pages(id_pages), .stat_absent(stat_absent),
    .leg_known(leg_known), .leg_cls(leg_cls), .leg_pages(leg_pages)
  );

  assign run_req   = start || boot_pend;
  assign busy      = (phase != PH_IDLE);
  assign need_stat = !mfr_hit || (id_known && id_dual_mode);

  always_comb begin
    launch    = 1'b0;
    launch_op = OP_READ_ID;
    launch_n  = CNT_W'(ID_BYTES);
    fin       = 1'b0;
    fin_fault = FLT_NONE;
    fin_cls   = 2'd0;
    fin_pow2  = 1'b0;
    fin_pages = '0;
    fin_rev   = 1'b0;
    case (phase)
      PH_IDLE: launch = run_req;
      PH_ID_CHK: begin
        if (need_stat) begin
          launch    = 1'b1;
          launch_op = OP_READ_STAT;
          launch_n  = CNT_W'(1);
        end else begin
          fin = 1'b1;
          if (id_known) begin
            fin_cls   = id_cls;
            fin_pages = id_pages;
          end else begin
            fin_fault = FLT_UNSUP;
          end
        end
      end
      PH_ST_CHK: begin
        fin = 1'b1;
        if (jedec_q) begin
          fin_cls   = id_cls;
          fin_pages = id_pages;
          fin_pow2  = stat_q[0];
          fin_rev   = 1'b1;
        end else if (stat_absent) begin
          fin_fault = FLT_ABSENT;
        end else if (leg_known) begin
          fin_cls   = leg_cls;
          fin_pages = leg_pages;
        end else begin
          fin_fault = FLT_UNSUP;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      boot_pend  <= 1'b1;
      jedec_q    <= 1'b0;
      stat_q     <= 8'h00;
      for (int i = 0; i < KEY_BYTES; i++) id_q[i] <= 8'h00;
      geo_valid  <= 1'b0;
      geo_fault  <= FLT_NONE;
      page_bytes <= '0;
      page_shift <= '0;
      page_count <= '0;
      rev_d      <= 1'b0;
    end else begin
      geo_valid <= 1'b0;
      if (phase == PH_ID_RUN && rx_stb && rx_idx < CNT_W'(KEY_BYTES))
        id_q[rx_idx[1:0]] <= rx_byte;
      if (phase == PH_ST_RUN && rx_stb)
        stat_q <= rx_byte;
      case (phase)
        PH_IDLE:   if (run_req) begin phase <= PH_ID_RUN; boot_pend <= 1'b0; end
        PH_ID_RUN: if (frame_end) phase <= PH_ID_CHK;
        PH_ST_RUN: if (frame_end) phase <= PH_ST_CHK;
        PH_ID_CHK: if (need_stat) begin phase <= PH_ST_RUN; jedec_q <= mfr_hit; end
                   else phase <= PH_IDLE;
        PH_ST_CHK: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
      if (fin) begin
        geo_valid  <= 1'b1;
        geo_fault  <= fin_fault;
        rev_d      <= fin_rev;
        page_count <= fin_pages;
        page_bytes <= (fin_fault == FLT_NONE) ? geo_bytes(fin_cls, fin_pow2) : '0;
        page_shift <= (fin_fault == FLT_NONE) ? geo_shift(fin_cls, fin_pow2) : '0;
      end
    end
  end

endmodule

// File: rtl/sfg_ident_chk.sv
module sfg_ident_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        xfer_go,
  input logic [7:0]  xfer_tx,
  input logic        busy,
  input logic        geo_valid,
  input logic [1:0]  geo_fault,
  input logic [10:0] page_bytes,
  input logic        launch
);

  p_go_in_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> !cs_n);

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);

  p_frame_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (xfer_go && xfer_tx != 8'h00));

  p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !$fell(cs_n)) |-> (xfer_tx == 8'h00));

  p_launch_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> $fell(cs_n));

  p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    geo_valid |=> !geo_valid);

  p_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    geo_valid |-> (cs_n && !busy));

  p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (geo_valid && geo_fault != 2'd0) |-> (page_bytes == 11'd0));

endmodule

bind sfg_ident sfg_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
  .busy(busy), .geo_valid(geo_valid), .geo_fault(geo_fault),
  .page_bytes(page_bytes), .launch(launch)
);

// File: tb/sfg_ident_test.sv
module sfg_ident_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cs_n, xfer_go;
  logic [7:0]  xfer_tx;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;
  logic        busy, geo_valid, rev_d;
  logic [1:0]  geo_fault;
  logic [10:0] page_bytes;
  logic [3:0]  page_shift;
  logic [13:0] page_count;

  always #2 clk = ~clk;

  sfg_ident uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .xfer_go(xfer_go),
    .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx), .busy(busy),
    .geo_valid(geo_valid), .geo_fault(geo_fault), .page_bytes(page_bytes),
    .page_shift(page_shift), .page_count(page_count), .rev_d(rev_d)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
      $finish;
    end
  end

  // serializer model plus per-clock pin checks
  logic [7:0] rid [5];
  logic [7:0] rstat;
  logic [7:0] ops [2];
  logic [7:0] pend_rx;
  int nbyte = 0, frames = 0, wait_n = 0, bad_dummy = 0;
  int bytes_f [2];

  always @(negedge clk) begin
    xfer_done = 1'b0;
    if (cs_n) nbyte = 0;
    if (wait_n > 0) begin
      wait_n--;
      if (wait_n == 0) begin
        xfer_done = 1'b1;
        xfer_rx   = pend_rx;
      end
    end
    if (xfer_go) begin
      chk("R12 go with pending exchange", wait_n, 0);
      if (nbyte == 0) begin
        if (frames < 2) ops[frames] = xfer_tx;
        frames++;
        pend_rx = 8'h00;
      end else begin
        if (xfer_tx != 8'h00) bad_dummy++;
        if (frames >= 1 && frames <= 2 && ops[frames-1] == 8'h9F)
          pend_rx = (nbyte <= 5) ? rid[nbyte-1] : 8'h00;
        else
          pend_rx = rstat;
      end
      if (frames >= 1 && frames <= 2) bytes_f[frames-1]++;
      nbyte++;
      wait_n = 2;
    end
    if (rst_n) begin
      if (!busy) chk("R1 cs_n high while idle", int'(cs_n), 1);
      if (xfer_go) chk("R12 go only inside frame", int'(cs_n), 0);
    end
  end

  task automatic ref_geo(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] st,
                         output int eb, output int es, output int ep, output int er,
                         output int ef, output int efr);
    int p2b, p2s, xb, xs;
    bit dual, hit;
    eb = 0; es = 0; ep = 0; er = 0; ef = 0; efr = 2;
    p2b = 0; p2s = 0; xb = 0; xs = 0; dual = 1'b1; hit = 1'b1;
    if (b0 == 8'h1F) begin
      case ({b1, b2})
        16'h2200: begin ep = 512;  p2b = 256;  p2s = 8;  xb = 264;  xs = 9;  end
        16'h2300: begin ep = 1024; p2b = 256;  p2s = 8;  xb = 264;  xs = 9;  end
        16'h2400: begin ep = 2048; p2b = 256;  p2s = 8;  xb = 264;  xs = 9;  end
        16'h2500: begin ep = 4096; p2b = 256;  p2s = 8;  xb = 264;  xs = 9;  end
        16'h2600: begin ep = 4096; p2b = 512;  p2s = 9;  xb = 528;  xs = 10; end
        16'h2701: begin ep = 8192; p2b = 512;  p2s = 9;  xb = 528;  xs = 10; end
        16'h2800: begin ep = 8192; p2b = 1024; p2s = 10; xb = 1056; xs = 11; end
        16'h2700: begin ep = 8192; xb = 528; xs = 10; dual = 1'b0; end
        default:  hit = 1'b0;
      endcase
      if (!hit) begin ef = 2; efr = 1; ep = 0; end
      else if (!dual) begin eb = xb; es = xs; efr = 1; end
      else begin
        er = 1;
        if (st[0]) begin eb = p2b; es = p2s; end
        else begin eb = xb; es = xs; end
      end
    end else begin
      if (st == 8'h00 || st == 8'hFF) ef = 1;
      else begin
        case (st & 8'h3C)
          8'h0C: begin ep = 512;  eb = 264;  es = 9;  end
          8'h14: begin ep = 1024; eb = 264;  es = 9;  end
          8'h1C: begin ep = 2048; eb = 264;  es = 9;  end
          8'h24: begin ep = 4096; eb = 264;  es = 9;  end
          8'h2C: begin ep = 4096; eb = 528;  es = 10; end
          8'h34: begin ep = 8192; eb = 528;  es = 10; end
          8'h38, 8'h3C: begin ep = 8192; eb = 1056; es = 11; end
          default: ef = 2;
        endcase
      end
    end
  endtask

  task automatic run_case(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] st,
                          input bit kick, input bit poke);
    int eb, es, ep, er, ef, efr;
    bit seen;
    rid[0] = b0; rid[1] = b1; rid[2] = b2; rid[3] = 8'h01; rid[4] = 8'h00;
    rstat = st;
    frames = 0; bad_dummy = 0; bytes_f[0] = 0; bytes_f[1] = 0;
    ops[0] = 8'h00; ops[1] = 8'h00;
    ref_geo(b0, b1, b2, st, eb, es, ep, er, ef, efr);
    if (kick) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      start = poke && (i == 12);
      if (geo_valid) seen = 1'b1;
    end
    start = 1'b0;
    chk({tag, " R11 strobe seen"}, int'(seen), 1);
    chk({tag, " R11 busy low at strobe"}, int'(busy), 0);
    chk({tag, " R10 fault code"}, int'(geo_fault), ef);
    chk({tag, " R4 R5 page bytes"}, int'(page_bytes), eb);
    chk({tag, " R4 R5 page shift"}, int'(page_shift), es);
    chk({tag, " R7 R8 page count"}, int'(page_count), ep);
    chk({tag, " R6 revision class"}, int'(rev_d), er);
    chk({tag, " R6 R10 frame count"}, frames, efr);
    chk({tag, " R2 id opcode"}, int'(ops[0]), 'h9F);
    chk({tag, " R2 id frame length"}, bytes_f[0], 6);
    chk({tag, " R2 dummy bytes zero"}, bad_dummy, 0);
    if (efr == 2) begin
      chk({tag, " R4 R8 status opcode"}, int'(ops[1]), 'hD7);
      chk({tag, " R3 status frame length"}, bytes_f[1], 2);
    end
    @(negedge clk);
    chk({tag, " R11 strobe one cycle"}, int'(geo_valid), 0);
    if (poke) begin
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        chk({tag, " R11 start while busy ignored"}, int'(busy), 0);
      end
      chk({tag, " R11 no extra frame"}, frames, efr);
    end
  endtask

  initial begin
    rid[0] = 8'h1F; rid[1] = 8'h23; rid[2] = 8'h00; rid[3] = 8'h01; rid[4] = 8'h00;
    rstat = 8'h01;
    bytes_f[0] = 0; bytes_f[1] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", int'(cs_n), 1);
    chk("R1 reset strobe", int'(geo_valid), 0);
    chk("R1 reset page bytes", int'(page_bytes), 0);
    chk("R1 reset page count", int'(page_count), 0);
    chk("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    run_case("R1 auto run 1F2300 binary", 8'h1F, 8'h23, 8'h00, 8'h01, 1'b0, 1'b0);
    run_case("R5 1F2800 extended", 8'h1F, 8'h28, 8'h00, 8'h00, 1'b1, 1'b0);
    run_case("R4 1F2800 binary", 8'h1F, 8'h28, 8'h00, 8'hA5, 1'b1, 1'b0);
    run_case("R6 1F2700 single mode", 8'h1F, 8'h27, 8'h00, 8'h01, 1'b1, 1'b0);
    run_case("R4 1F2701 binary", 8'h1F, 8'h27, 8'h01, 8'h81, 1'b1, 1'b0);
    run_case("R5 1F2600 extended", 8'h1F, 8'h26, 8'h00, 8'h3C, 1'b1, 1'b0);
    run_case("R7 1F2200 binary", 8'h1F, 8'h22, 8'h00, 8'h01, 1'b1, 1'b0);
    run_case("R7 1F2400 extended", 8'h1F, 8'h24, 8'h00, 8'h00, 1'b1, 1'b0);
    run_case("R7 1F2500 binary", 8'h1F, 8'h25, 8'h00, 8'hFF, 1'b1, 1'b0);
    run_case("R10 1F2900 unlisted", 8'h1F, 8'h29, 8'h00, 8'h01, 1'b1, 1'b0);
    run_case("R10 1F2702 unlisted", 8'h1F, 8'h27, 8'h02, 8'h01, 1'b1, 1'b0);
    run_case("R8 density 7", 8'hFF, 8'hFF, 8'hFF, 8'h9C, 1'b1, 1'b0);
    run_case("R8 density E", 8'h00, 8'h00, 8'h00, 8'hB8, 1'b1, 1'b0);
    run_case("R8 density F", 8'h00, 8'h00, 8'h00, 8'h3D, 1'b1, 1'b0);
    run_case("R8 density 3", 8'h1E, 8'h23, 8'h00, 8'h0C, 1'b1, 1'b0);
    run_case("R8 density 5", 8'h00, 8'h00, 8'h00, 8'h94, 1'b1, 1'b0);
    run_case("R8 density 9", 8'h00, 8'h00, 8'h00, 8'h24, 1'b1, 1'b0);
    run_case("R8 density B", 8'h00, 8'h00, 8'h00, 8'hAE, 1'b1, 1'b0);
    run_case("R8 density D", 8'h00, 8'h00, 8'h00, 8'h34, 1'b1, 1'b0);
    run_case("R9 status all ones", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0);
    run_case("R9 status zero", 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    run_case("R10 density 4", 8'h00, 8'h00, 8'h00, 8'h90, 1'b1, 1'b0);
    run_case("R11 start while busy", 8'h1F, 8'h28, 8'h00, 8'h01, 1'b1, 1'b1);
    report();
    $finish;
  end

endmodule